// File: doc/BRIEF.md
# Accumulator and Carry-Flag Logic Unit

This unit holds a 16-bit accumulator and a 1-bit extend/carry flag, and works out their next values when a control sequencer hands it an operation. Memory-operand operations combine the accumulator with a 16-bit data word from the data register: bitwise AND, add with carry-out, or plain load. An input transfer drops an 8-bit character into the low byte. A register-reference operation takes a 12-bit field in which each bit names one action. These actions include clearing, complementing, rotating through the flag, incrementing, four conditional skips and a halt.

One operation is presented per cycle with `op_valid` high. The accumulator and flag take their new values at that clock edge. The skip and halt requests are registered one-cycle pulses in the following cycle, for use by the program-counter logic and the run/stop control. Every operation completes in a single cycle and the unit never stalls, so the input carries no ready signal. The sequencer may present a new operation on every cycle, and an operation is accepted whenever `op_valid` is high.

Top module: `acc_unit`

## Requirements
- R1: While `rst_n` is low, `acc_q`, `flag_q`, `skip_req` and `halt_req` are all 0.
- R2: `op_kind` selects the operation at an edge where `op_valid` is 1: 0 is AND, 1 is ADD, 2 is LOAD, 3 is register-reference, and 4 is INPUT. With `op_valid` low, or with `op_kind` 5 to 7, the accumulator and flag keep their values and `skip_req` and `halt_req` are 0 in the next cycle.
- R3: ADD sets {flag, accumulator} to the 17-bit sum of the accumulator and `data_in`, so the flag receives the carry-out.
- R4: AND sets the accumulator to its bitwise AND with `data_in`, and the flag is unchanged.
- R5: LOAD copies `data_in` into the accumulator, and the flag is unchanged.
- R6: INPUT puts `char_in` into accumulator bits 7:0, and leaves bits 15:8 and the flag unchanged.
- R7: In a register-reference field, bit 11 clears the accumulator, bit 10 clears the flag, bit 9 inverts the accumulator and bit 8 inverts the flag.
- R8: Field bit 7 rotates {accumulator, flag} right: the old flag enters bit 15 and old bit 0 goes to the flag. Field bit 6 rotates left: the old flag enters bit 0 and old bit 15 goes to the flag.
- R9: Field bit 5 adds 1 to the accumulator modulo 2^16, and the flag is unchanged.
- R10: When several of field bits 11 to 5 are set, their actions apply in descending bit order, and each action works on the result of the one before it.
- R11: Field bits 4, 3, 2 and 1 raise `skip_req` in the next cycle when, respectively, accumulator bit 15 is 0, accumulator bit 15 is 1, the accumulator is zero, or the flag is 0. The conditions are tested on the values held before the operation, and `skip_req` is the OR of all enabled conditions.
- R12: Field bit 0 raises `halt_req` in the next cycle, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation selector (see R2) |
| data_in | input | 16 | Data-register operand |
| field | input | 12 | Register-reference action bits |
| char_in | input | 8 | Input character |
| acc_q | output | 16 | Accumulator |
| flag_q | output | 1 | Extend/carry flag |
| skip_req | output | 1 | Skip-next-instruction pulse |
| halt_req | output | 1 | Halt pulse |

## Verification
Every single field bit is applied from a set of accumulator patterns, with the flag both 0 and 1. The patterns include zero, all ones, the lone sign bit, the lone low bit, the largest positive value and mixed values. This separates the rotate directions, the sign and zero skips, and an increment that wraps from a flag change. Every pair of field bits is then applied, which exposes any deviation from the descending order and any skip that fails to OR. ADD is swept over a grid of operands to tell carry-out from no carry. AND, LOAD and INPUT are checked with the flag set, so that a flag they should leave alone is caught. Idle cycles and the unused op codes are driven with all field bits set, to confirm that nothing changes.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_ADD   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_REG   = 3'd3,
    OP_INPUT = 3'd4
  } op_kind_t;

  localparam int FIELD_W  = 12;
  localparam int TOP_BIT  = FIELD_W - 1;
  // actions run from field bit 11 down to bit 5
  localparam int NSTAGE   = 7;
  localparam int B_SKPOS  = 4;
  localparam int B_SKNEG  = 3;
  localparam int B_SKZERO = 2;
  localparam int B_SKFLG  = 1;
  localparam int B_HALT   = 0;
endpackage

// File: rtl/acc_regchain.sv
module acc_regchain #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]              acc_i,
  input  logic                       flag_i,
  input  logic [acc_pkg::FIELD_W-1:0] field_i,
  output logic [DW-1:0]              acc_o,
  output logic                       flag_o
);
  import acc_pkg::*;

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  // state word: {flag, accumulator}
  function automatic logic [DW:0] apply_stage(input int k, input logic [DW:0] s);
    logic [DW-1:0] a;
    logic          f;
    a = s[DW-1:0];
    f = s[DW];
    case (k)
      0: a = '0;
      1: f = 1'b0;
      2: a = ~a;
      3: f = ~f;
      4: {a, f} = {f, a};
      5: {f, a} = {a, f};
      6: a = a + ONE;
      default: ;
    endcase
    return {f, a};
  endfunction

  logic [DW:0] chain [NSTAGE+1];

  assign chain[0] = {flag_i, acc_i};

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    assign chain[k+1] = field_i[TOP_BIT-k] ? apply_stage(k, chain[k]) : chain[k];
  end

  assign acc_o  = chain[NSTAGE][DW-1:0];
  assign flag_o = chain[NSTAGE][DW];
endmodule

// File: rtl/acc_memop.sv
module acc_memop #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  acc_pkg::op_kind_t kind_i,
  input  logic [DW-1:0]     acc_i,
  input  logic              flag_i,
  input  logic [DW-1:0]     data_i,
  input  logic [CW-1:0]     char_i,
  output logic [DW-1:0]     acc_o,
  output logic              flag_o
);
  import acc_pkg::*;

  logic [DW:0] sum;

  assign sum = {1'b0, acc_i} + {1'b0, data_i};

  always_comb begin
    acc_o  = acc_i;
    flag_o = flag_i;
    case (kind_i)
      OP_AND:   acc_o = acc_i & data_i;
      OP_ADD:   {flag_o, acc_o} = sum;
      OP_LOAD:  acc_o = data_i;
      OP_INPUT: acc_o = {acc_i[DW-1:CW], char_i};
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_cond.sv
module acc_cond #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]               acc_i,
  input  logic                        flag_i,
  input  logic [acc_pkg::FIELD_W-1:0] field_i,
  output logic                        skip_o,
  output logic                        halt_o
);
  import acc_pkg::*;

  logic sign;
  logic zero;

  assign sign = acc_i[DW-1];
  assign zero = (acc_i == '0);

  assign skip_o = (field_i[B_SKPOS]  & ~sign)
                | (field_i[B_SKNEG]  &  sign)
                | (field_i[B_SKZERO] &  zero)
                | (field_i[B_SKFLG]  & ~flag_i);
  assign halt_o = field_i[B_HALT];
endmodule

// File: rtl/acc_unit.sv
module acc_unit #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [DW-1:0] data_in,
  input  logic [11:0]   field,
  input  logic [CW-1:0] char_in,
  output logic [DW-1:0] acc_q,
  output logic          flag_q,
  output logic          skip_req,
  output logic          halt_req
);
  import acc_pkg::*;

  op_kind_t      kind;
  logic [DW-1:0] reg_acc, mem_acc;
  logic          reg_flag, mem_flag;
  logic          skip_c, halt_c;
  logic          is_reg, is_mem;

  assign kind   = op_kind_t'(op_kind);
  assign is_reg = op_valid && (kind == OP_REG);
  assign is_mem = op_valid && (kind == OP_AND || kind == OP_ADD ||
                               kind == OP_LOAD || kind == OP_INPUT);

  acc_regchain #(.DW(DW)) u_chain (
    .acc_i  (acc_q),
    .flag_i (flag_q),
    .field_i(field),
    .acc_o  (reg_acc),
    .flag_o (reg_flag)
  );

  acc_memop #(.DW(DW), .CW(CW)) u_mem (
    .kind_i (kind),
    .acc_i  (acc_q),
    .flag_i (flag_q),
    .data_i (data_in),
    .char_i (char_in),
    .acc_o  (mem_acc),
    .flag_o (mem_flag)
  );

  acc_cond #(.DW(DW)) u_cond (
    .acc_i  (acc_q),
    .flag_i (flag_q),
    .field_i(field),
    .skip_o (skip_c),
    .halt_o (halt_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      flag_q   <= 1'b0;
      skip_req <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      if (is_reg) begin
        acc_q  <= reg_acc;
        flag_q <= reg_flag;
      end else if (is_mem) begin
        acc_q  <= mem_acc;
        flag_q <= mem_flag;
      end
      skip_req <= is_reg && skip_c;
      halt_req <= is_reg && halt_c;
    end
  end
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_kind,
  input logic [DW-1:0] data_in,
  input logic [11:0]   field,
  input logic [CW-1:0] char_in,
  input logic [DW-1:0] acc_q,
  input logic          flag_q,
  input logic          skip_req,
  input logic          halt_req
);
  import acc_pkg::*;

  logic idle;
  assign idle = !op_valid || (op_kind > 3'd4);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(acc_q) && $stable(flag_q) && !skip_req && !halt_req));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd1) |=>
      ({flag_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(data_in)})));

  assert_and_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd0) |=>
      ($stable(flag_q) && acc_q == ($past(acc_q) & $past(data_in))));

  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd2) |=> (acc_q == $past(data_in) && $stable(flag_q)));

  assert_input_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4) |=>
      (acc_q[CW-1:0] == $past(char_in) && $stable(acc_q[DW-1:CW]) && $stable(flag_q)));

  assert_skip_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> $past(op_valid && op_kind == 3'd3 && field[4:1] != 4'd0));

  assert_halt_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd3) |=> (halt_req == $past(field[0])));
endmodule

bind acc_unit acc_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .op_kind (op_kind),
  .data_in (data_in),
  .field   (field),
  .char_in (char_in),
  .acc_q   (acc_q),
  .flag_q  (flag_q),
  .skip_req(skip_req),
  .halt_req(halt_req)
);

// File: tb/acc_unit_tb.sv
module acc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [15:0] data_in = '0;
  logic [11:0] field = '0;
  logic [7:0]  char_in = '0;
  logic [15:0] acc_q;
  logic        flag_q, skip_req, halt_req;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_acc = '0;
  logic        m_flag = 1'b0;

  logic [15:0] pats [7] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                            16'h7FFF, 16'hA5A5, 16'h1234};

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .data_in(data_in), .field(field), .char_in(char_in),
    .acc_q(acc_q), .flag_q(flag_q), .skip_req(skip_req), .halt_req(halt_req)
  );

  // returns {skip, halt, flag, acc}
  function automatic logic [18:0] model(input logic v, input logic [2:0] k,
      input logic [15:0] a, input logic f, input logic [15:0] d,
      input logic [11:0] fl, input logic [7:0] c);
    logic [15:0] na;
    logic        nf, sk, h;
    logic [16:0] s;
    na = a; nf = f; sk = 1'b0; h = 1'b0;
    if (v) begin
      case (k)
        3'd0: na = a & d;
        3'd1: begin s = {1'b0, a} + {1'b0, d}; na = s[15:0]; nf = s[16]; end
        3'd2: na = d;
        3'd3: begin
          if (fl[11]) na = 16'h0000;
          if (fl[10]) nf = 1'b0;
          if (fl[9])  na = ~na;
          if (fl[8])  nf = ~nf;
          if (fl[7])  {na, nf} = {nf, na};
          if (fl[6])  {nf, na} = {na, nf};
          if (fl[5])  na = na + 16'd1;
          sk = (fl[4] && !a[15]) || (fl[3] && a[15]) ||
               (fl[2] && a == 16'h0) || (fl[1] && !f);
          h = fl[0];
        end
        3'd4: na = {a[15:8], c};
        default: ;
      endcase
    end
    return {sk, h, nf, na};
  endfunction

  task automatic compare(input string tag, input logic [18:0] exp);
    checks++;
    if ({skip_req, halt_req, flag_q, acc_q} !== exp) begin
      errors++;
      $display("FAIL %s actual skip=%b halt=%b flag=%b acc=%h expected skip=%b halt=%b flag=%b acc=%h",
               tag, skip_req, halt_req, flag_q, acc_q, exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic do_op(input string tag, input logic v, input logic [2:0] k,
      input logic [15:0] d, input logic [11:0] fl, input logic [7:0] c);
    logic [18:0] exp;
    exp = model(v, k, m_acc, m_flag, d, fl, c);
    op_valid = v; op_kind = k; data_in = d; field = fl; char_in = c;
    @(negedge clk);
    op_valid = 1'b0;
    compare(tag, exp);
    m_acc = exp[15:0];
    m_flag = exp[16];
  endtask

  // bring accumulator and flag to a known state via the normal ops
  task automatic set_state(input logic [15:0] a, input logic f);
    do_op("R7", 1'b1, 3'd3, 16'h0, 12'h400, 8'h0);
    if (f) do_op("R7", 1'b1, 3'd3, 16'h0, 12'h100, 8'h0);
    do_op("R5", 1'b1, 3'd2, a, 12'h0, 8'h0);
  endtask

  function automatic string bit_tag(input int b);
    if (b >= 8) return "R7";
    if (b >= 6) return "R8";
    if (b == 5) return "R9";
    if (b >= 1) return "R11";
    return "R12";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", 19'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 19'h0);

    // single action bits over every pattern and flag value
    for (int p = 0; p < 7; p++)
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 12; b++) begin
          set_state(pats[p], f[0]);
          do_op(bit_tag(b), 1'b1, 3'd3, 16'h0, 12'(1 << b), 8'h0);
        end

    // every pair of bits: ordering (R10) and OR of skips (R11)
    for (int p = 0; p < 7; p += 2)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < i; j++) begin
          set_state(pats[p], p[1]);
          do_op((i >= 5 && j >= 5) ? "R10" : "R11", 1'b1, 3'd3, 16'h0,
                12'((1 << i) | (1 << j)), 8'h0);
        end

    // ADD grid with carry-out
    for (int p = 0; p < 7; p++)
      for (int q = 0; q < 7; q++) begin
        set_state(pats[p], q[0]);
        do_op("R3", 1'b1, 3'd1, pats[q], 12'h0, 8'h0);
      end

    // AND, LOAD, INPUT with flag set
    for (int p = 0; p < 7; p++) begin
      set_state(pats[p], 1'b1);
      do_op("R4", 1'b1, 3'd0, pats[(p + 3) % 7], 12'h0, 8'h0);
      set_state(pats[p], 1'b1);
      do_op("R6", 1'b1, 3'd4, 16'h0, 12'h0, 8'(pats[(p + 5) % 7]));
      do_op("R5", 1'b1, 3'd2, pats[(p + 1) % 7], 12'h0, 8'h0);
    end

    // idle and unused codes leave everything alone
    set_state(16'hC3C3, 1'b1);
    do_op("R2", 1'b0, 3'd3, 16'hFFFF, 12'hFFF, 8'hFF);
    for (int k = 5; k < 8; k++)
      do_op("R2", 1'b1, 3'(k), 16'hFFFF, 12'hFFF, 8'hFF);
    do_op("R12", 1'b1, 3'd3, 16'h0, 12'h001, 8'h0);
    do_op("R12", 1'b0, 3'd0, 16'h0, 12'h0, 8'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule